// File: doc/BRIEF.md
# Banked Memory Map Controller

This block holds the two control registers that shape the memory map of a small 8-bit controller whose program flash is larger than its 64 KB address space. One register picks the flash bank that shows through the upper 32 KB of CODE space. The other register does two things. It picks the flash bank that shows through the upper 32 KB of XDATA space, and it carries an enable that lays on-chip SRAM over the start of the upper CODE window, so that code can run from RAM.

The CPU reaches both registers through a byte-wide special-function register port. The port has an address, write data, a write strobe and a combinational read-back. Two independent translation ports take a 16-bit CODE address and a 16-bit XDATA address. For each one they return a target select (none, flash or SRAM) and a physical address. The translation is purely combinational. A register write takes effect at the clock edge that samples the strobe.

The parameter `FLASH_KB` (32, 64, 96, 128 or 256) fixes the highest legal bank number. Bank numbers above that limit are refused when written. `SRAM_SIZE` gives the byte length of the overlay.

Top module: `bank_map_ctrl`

## Requirements
- R1: After reset the CODE bank field is 1, the overlay enable is 0 and the XDATA bank field is 0.
- R2: With `sfr_addr` = 0x9F, `sfr_rdata` is {5'b0, CODE bank}. With `sfr_addr` = 0xC7, it is {4'b0, overlay enable, XDATA bank}, with the overlay enable at bit 3 and the XDATA bank at bits 2:0. Any other address reads 0x00.
- R3: A write strobe to 0x9F loads `sfr_wdata[2:0]` into the CODE bank. A write strobe to 0xC7 loads bit 3 into the overlay enable and bits 2:0 into the XDATA bank. The new value is visible after the next rising clock edge. Writes to other addresses change nothing.
- R4: The largest legal bank number is 0, 1, 2, 3 or 7 for `FLASH_KB` = 32, 64, 96, 128 or 256. A written bank value above that limit leaves its bank field unchanged. The overlay enable bit written in the same cycle is still loaded.
- R5: Target codes are 0 = none, 1 = flash and 2 = SRAM. A CODE address in 0x8000–0xFFFF that is not taken by the overlay maps to flash with physical address {CODE bank, addr[14:0]}.
- R6: A CODE address below 0x8000 maps to flash with physical address equal to the logical address.
- R7: With the overlay enabled, a CODE address in 0x8000 to 0x8000+SRAM_SIZE−1 maps to SRAM with physical address addr−0x8000. Higher CODE addresses fall back to the R5 mapping.
- R8: An XDATA address in 0x8000–0xFFFF maps to flash with physical address {XDATA bank, addr[14:0]}. An XDATA address below 0x8000 gives target none with physical address equal to the logical address.
- R9: With `FLASH_KB` = 32 the CODE bank field never changes on any write. A CODE window access with a bank above the legal limit that the overlay does not take gives target none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfr_addr | input | 8 | Register address |
| sfr_wdata | input | 8 | Register write data |
| sfr_we | input | 1 | Write strobe |
| sfr_rdata | output | 8 | Read data for the addressed register |
| code_addr | input | 16 | Logical CODE address |
| code_tgt | output | 2 | CODE target select (0 none, 1 flash, 2 SRAM) |
| code_paddr | output | 18 | CODE physical address |
| xdata_addr | input | 16 | Logical XDATA address |
| xdata_tgt | output | 2 | XDATA target select (0 none, 1 flash) |
| xdata_paddr | output | 18 | XDATA physical address |

## Verification
On every clock the assertions check several things. A refused bank value leaves its field unchanged while the overlay bit is still loaded. Without a strobe the registers hold. The 32 KB build never changes its CODE bank. An SRAM hit always lies inside the overlay window. Low addresses translate to themselves. Only the bench's scenarios show the rest: the reset values, the exact read-back layout, the exact flash address for each bank, and the fall-back above the overlay end. They also show the 32 KB build driving target none, since that needs a second instance and a reference model that follows each write.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

    localparam int BANK_W = 3;
    localparam int PADDR_W = BANK_W + 15;
    localparam logic [7:0] SFR_CBANK = 8'h9F;
    localparam logic [7:0] SFR_MCTL = 8'hC7;

    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_FLASH = 2'd1,
        TGT_SRAM  = 2'd2
    } tgt_e;

    typedef struct packed {
        logic [BANK_W-1:0] cbank;
        logic              ovl;
        logic [BANK_W-1:0] xbank;
    } map_regs_t;

    function automatic int max_bank(input int kb);
        case (kb)
            32:      return 0;
            64:      return 1;
            96:      return 2;
            128:     return 3;
            default: return 7;
        endcase
    endfunction

endpackage

// File: rtl/bmc_regs.sv
module bmc_regs
    import bmc_pkg::*;
#(
    parameter int FLASH_KB = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] sfr_addr,
    input  logic [7:0] sfr_wdata,
    input  logic       sfr_we,
    output logic [7:0] sfr_rdata,
    output map_regs_t  regs
);
    localparam int MAXB = max_bank(FLASH_KB);
    localparam logic [BANK_W-1:0] MAXB_V = BANK_W'(MAXB);
    localparam bit CBANK_LOCKED = (FLASH_KB == 32);

    map_regs_t regs_d, regs_q;
    logic      bank_ok;

    always_comb begin
        regs_d  = regs_q;
        bank_ok = (sfr_wdata[BANK_W-1:0] <= MAXB_V);
        if (sfr_we) begin
            if (sfr_addr == SFR_CBANK && bank_ok && !CBANK_LOCKED) begin
                regs_d.cbank = sfr_wdata[BANK_W-1:0];
            end
            if (sfr_addr == SFR_MCTL) begin
                regs_d.ovl = sfr_wdata[3];
                if (bank_ok) begin
                    regs_d.xbank = sfr_wdata[BANK_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{cbank: BANK_W'(1), ovl: 1'b0, xbank: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        case (sfr_addr)
            SFR_CBANK: sfr_rdata = {5'b0, regs_q.cbank};
            SFR_MCTL:  sfr_rdata = {4'b0, regs_q.ovl, regs_q.xbank};
            default:   sfr_rdata = 8'h00;
        endcase
    end

    assign regs = regs_q;

    // R4: refused XDATA bank keeps its value, overlay bit still loads
    a_r4_bad_bank_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_we && sfr_addr == SFR_MCTL && sfr_wdata[BANK_W-1:0] > MAXB_V)
        |=> ($stable(regs_q.xbank) && regs_q.ovl == $past(sfr_wdata[3])));

    // R3: no strobe, no change
    a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !sfr_we |=> $stable(regs_q));

    a_r4_bank_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_we |=> (regs_q.xbank <= MAXB_V));

    generate
        if (CBANK_LOCKED) begin : g_lock_chk
            a_r9_cbank_locked: assert property (@(posedge clk) disable iff (!rst_n)
                sfr_we |=> $stable(regs_q.cbank));
        end
    endgenerate

endmodule

// File: rtl/bmc_xlate.sv
module bmc_xlate
    import bmc_pkg::*;
#(
    parameter int  FLASH_KB  = 128,
    parameter int  SRAM_SIZE = 8192,
    parameter bit  IS_CODE   = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [15:0]        addr,
    input  logic [BANK_W-1:0]  bank,
    input  logic               ovl,
    output logic [1:0]         tgt,
    output logic [PADDR_W-1:0] paddr
);
    localparam logic [BANK_W-1:0] MAXB_V = BANK_W'(max_bank(FLASH_KB));
    localparam logic [15:0] SRAM_LIM = 16'(SRAM_SIZE);

    logic in_win, sram_hit, bank_ok;
    tgt_e tgt_w;

    always_comb begin
        in_win   = addr[15];
        bank_ok  = (bank <= MAXB_V);
        sram_hit = IS_CODE && ovl && in_win && ({1'b0, addr[14:0]} < SRAM_LIM);
        if (!in_win) begin
            tgt_w = IS_CODE ? TGT_FLASH : TGT_NONE;
            paddr = PADDR_W'(addr);
        end else if (sram_hit) begin
            tgt_w = TGT_SRAM;
            paddr = PADDR_W'(addr[14:0]);
        end else begin
            tgt_w = bank_ok ? TGT_FLASH : TGT_NONE;
            paddr = {bank, addr[14:0]};
        end
        tgt = tgt_w;
    end

    // R7: an SRAM hit always lies in the overlay window
    a_r7_sram_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt == TGT_SRAM) |-> (addr[15] && {1'b0, addr[14:0]} < SRAM_LIM && ovl));

    // R6 / R8: low addresses translate to themselves
    a_r6_low_identity: assert property (@(posedge clk) disable iff (!rst_n)
        !addr[15] |-> (paddr == PADDR_W'(addr) && tgt != TGT_SRAM));

endmodule

// File: rtl/bank_map_ctrl.sv
module bank_map_ctrl
    import bmc_pkg::*;
#(
    parameter int FLASH_KB  = 128,
    parameter int SRAM_SIZE = 8192
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [7:0]   sfr_addr,
    input  logic [7:0]   sfr_wdata,
    input  logic         sfr_we,
    output logic [7:0]   sfr_rdata,
    input  logic [15:0]  code_addr,
    output logic [1:0]   code_tgt,
    output logic [17:0]  code_paddr,
    input  logic [15:0]  xdata_addr,
    output logic [1:0]   xdata_tgt,
    output logic [17:0]  xdata_paddr
);
    map_regs_t regs;

    bmc_regs #(.FLASH_KB(FLASH_KB)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_we(sfr_we),
        .sfr_rdata(sfr_rdata), .regs(regs)
    );

    bmc_xlate #(.FLASH_KB(FLASH_KB), .SRAM_SIZE(SRAM_SIZE), .IS_CODE(1'b1)) u_code (
        .clk(clk), .rst_n(rst_n),
        .addr(code_addr), .bank(regs.cbank), .ovl(regs.ovl),
        .tgt(code_tgt), .paddr(code_paddr)
    );

    bmc_xlate #(.FLASH_KB(FLASH_KB), .SRAM_SIZE(SRAM_SIZE), .IS_CODE(1'b0)) u_xdata (
        .clk(clk), .rst_n(rst_n),
        .addr(xdata_addr), .bank(regs.xbank), .ovl(1'b0),
        .tgt(xdata_tgt), .paddr(xdata_paddr)
    );

endmodule

// File: tb/bank_map_ctrl_tb_top.sv
module bank_map_ctrl_tb_top;
    localparam int SRAM = 8192;

    logic clk = 0;
    logic rst_n = 0;
    logic [7:0] sfr_addr = 0, sfr_wdata = 0;
    logic sfr_we = 0;
    logic [15:0] code_addr = 0, xdata_addr = 0;
    logic [7:0] rd_a, rd_b;
    logic [1:0] ct_a, xt_a, ct_b, xt_b;
    logic [17:0] cp_a, xp_a, cp_b, xp_b;

    int vectors = 0, errors = 0, cycles = 0;
    // model state: index 0 = 128 KB build, index 1 = 32 KB build
    int cb[2], xm[2], xb[2], maxb[2];
    string wtag[2];

    always #10 clk = ~clk;

    bank_map_ctrl #(.FLASH_KB(128), .SRAM_SIZE(SRAM)) dut_i (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
        .sfr_we(sfr_we), .sfr_rdata(rd_a), .code_addr(code_addr), .code_tgt(ct_a),
        .code_paddr(cp_a), .xdata_addr(xdata_addr), .xdata_tgt(xt_a), .xdata_paddr(xp_a));

    bank_map_ctrl #(.FLASH_KB(32), .SRAM_SIZE(SRAM)) dut32_i (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
        .sfr_we(sfr_we), .sfr_rdata(rd_b), .code_addr(code_addr), .code_tgt(ct_b),
        .code_paddr(cp_b), .xdata_addr(xdata_addr), .xdata_tgt(xt_b), .xdata_paddr(xp_b));

    task automatic chk(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input int i, input int rd, input int ct, input int cp,
                           input int xt, input int xp);
        int a, etgt, epa, erd;
        string tg;
        // R2 read-back layout; after a write this also shows R3/R4/R9
        if (sfr_addr == 8'h9F) erd = cb[i];
        else if (sfr_addr == 8'hC7) erd = xm[i] * 8 + xb[i];
        else erd = 0;
        chk(wtag[i], $sformatf("rdata[%0d]", i), rd, erd);
        a = code_addr;
        if (a < 32768) begin etgt = 1; epa = a; tg = "R6"; end
        else if (xm[i] != 0 && a - 32768 < SRAM) begin etgt = 2; epa = a - 32768; tg = "R7"; end
        else if (cb[i] > maxb[i]) begin etgt = 0; epa = cb[i] * 32768 + (a % 32768); tg = "R9"; end
        else begin etgt = 1; epa = cb[i] * 32768 + (a % 32768); tg = "R5"; end
        chk(tg, $sformatf("code_tgt[%0d]", i), ct, etgt);
        chk(tg, $sformatf("code_paddr[%0d]", i), cp, epa);
        a = xdata_addr;
        if (a < 32768) begin etgt = 0; epa = a; end
        else begin etgt = 1; epa = xb[i] * 32768 + (a % 32768); end
        chk("R8", $sformatf("xdata_tgt[%0d]", i), xt, etgt);
        chk("R8", $sformatf("xdata_paddr[%0d]", i), xp, epa);
    endtask

    task automatic model_write(input int i);
        int v;
        wtag[i] = "R2";
        if (!sfr_we) return;
        v = sfr_wdata % 8;
        if (sfr_addr == 8'h9F) begin
            wtag[i] = (i == 1) ? "R9" : (v > maxb[i] ? "R4" : "R3");
            if (i == 0 && v <= maxb[i]) cb[i] = v;
        end else if (sfr_addr == 8'hC7) begin
            wtag[i] = (v > maxb[i]) ? "R4" : "R3";
            xm[i] = (sfr_wdata >> 3) & 1;
            if (v <= maxb[i]) xb[i] = v;
        end else begin
            wtag[i] = "R3";
        end
    endtask

    task automatic step(input logic we, input logic [7:0] sa, input logic [7:0] wd,
                        input logic [15:0] ca, input logic [15:0] xa);
        sfr_we = we; sfr_addr = sa; sfr_wdata = wd; code_addr = ca; xdata_addr = xa;
        #1;
        compare(0, rd_a, ct_a, cp_a, xt_a, xp_a);
        compare(1, rd_b, ct_b, cp_b, xt_b, xp_b);
        @(posedge clk);
        model_write(0);
        model_write(1);
        @(negedge clk);
    endtask

    initial begin
        int lfsr;
        maxb[0] = 3; maxb[1] = 0;
        for (int i = 0; i < 2; i++) begin
            cb[i] = 1; xm[i] = 0; xb[i] = 0; wtag[i] = "R1";
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset values seen through reads
        step(0, 8'h9F, 0, 16'h1234, 16'h0010);
        wtag[0] = "R1"; wtag[1] = "R1";
        step(0, 8'hC7, 0, 16'h8000, 16'h8000);
        // R3 legal writes, R5 window per bank
        step(1, 8'h9F, 8'hF2, 16'h9000, 16'hFFFF);
        step(0, 8'h9F, 0, 16'hFFFF, 16'h8001);
        step(1, 8'hC7, 8'h03, 16'h8000, 16'h8123);
        step(0, 8'hC7, 0, 16'hC000, 16'hFFFF);
        // R4 illegal bank, overlay bit still loads
        step(1, 8'hC7, 8'h0D, 16'h8000, 16'h9000);
        step(0, 8'hC7, 0, 16'h8000 + SRAM - 1, 16'h8000);
        step(0, 8'h9F, 0, 16'h8000 + SRAM, 16'h7FFF);
        step(1, 8'h9F, 8'h07, 16'hA000, 16'h0000);
        step(0, 8'h9F, 0, 16'hA000, 16'h0000);
        // R3 write to unrelated address
        step(1, 8'h55, 8'hFF, 16'h7FFF, 16'hFFFF);
        step(0, 8'h55, 0, 16'h8001, 16'h8000);
        step(0, 8'hC7, 0, 16'h8001, 16'h8000);
        // R9 locked bank in 32 KB build, overlay off
        step(1, 8'hC7, 8'h00, 16'h8000, 16'h8000);
        step(1, 8'h9F, 8'h00, 16'h8000, 16'hF000);
        step(0, 8'h9F, 0, 16'hE000, 16'h8000);
        // mixed pattern sweep
        lfsr = 32'h1ACE;
        for (int n = 0; n < 400; n++) begin
            lfsr = (lfsr * 1103515245 + 12345) & 32'h7FFFFFFF;
            step(lfsr[3:2] == 0,
                 lfsr[5] ? 8'hC7 : (lfsr[4] ? 8'h9F : 8'h20),
                 lfsr[15:8], lfsr[31:16], lfsr[27:12]);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule